// File: doc/BRIEF.md
# I2C Data Hold and Setup Timing Sequencer

This block times each data bit of an I2C transmitter that also owns the low phase of the clock line. The raw SCL line passes through a two-stage synchronizer and a digital noise filter. When a filtered falling edge is found, the block counts a programmable hold delay. It then drives the next data bit onto SDA. In stretching mode it keeps SCL pulled low for a programmable setup delay before letting it go. If the bit is not ready when the hold delay ends, SCL stays low until the bit arrives.

Both delays are counted in time quanta. One quantum lasts `presc + 1` kernel clocks. The hold delay is `hold_q` quanta and the setup delay is `setup_q + 1` quanta. In no-stretch mode the block never pulls SCL low. A bit that is missing at the end of the hold delay then raises a one-cycle underrun flag and releases SDA high.

Top module: `i2c_bit_timer`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) releases both lines (sda_pull=0, scl_pull=0), clears underrun and returns the sequencer to idle, even in the middle of a bit.
- R2: An SCL level change is accepted only after the synchronized line has differed from the accepted level for max(filt_len,1) consecutive samples (filt_len=0 bypasses the filter). A low pulse shorter than that starts no bit sequence.
- R3: With bit_valid high, let k be the first clock edge that samples scl_in low. Then sda_pull takes the value ~bit_data (1 pulls SDA low for a 0 bit, 0 releases it for a 1 bit) at edge k+3+max(filt_len,1)+hold_q*(presc+1). bit_taken is high in the cycle just before that edge.
- R4: In stretching mode (no_stretch=0), scl_pull rises at edge k+2+max(filt_len,1) and holds SCL low through the hold delay.
- R5: In stretching mode, scl_pull falls exactly (setup_q+1)*(presc+1) clock edges after the edge at which SDA took its new value. SDA never changes while scl_pull is low.
- R6: In stretching mode, if bit_valid is low when the hold delay ends, scl_pull stays high with SDA unchanged. At the first edge with bit_valid high, SDA takes the bit, and the full setup delay then runs before SCL is released.
- R7: In no-stretch mode, scl_pull is never asserted, and SDA timing follows R3.
- R8: In no-stretch mode, if bit_valid is low when the hold delay ends, underrun is high for exactly one cycle, starting at the edge given by R3. sda_pull is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| bit_data | input | 1 | Next data bit to drive |
| bit_valid | input | 1 | bit_data is ready |
| presc | input | 4 | Quantum length minus one, in kernel clocks |
| hold_q | input | 4 | Hold delay in quanta |
| setup_q | input | 4 | Setup delay in quanta minus one |
| filt_len | input | 4 | Digital filter length in samples, 0 bypasses |
| no_stretch | input | 1 | 1: never pull SCL low |
| bit_taken | output | 1 | bit_data is consumed at the next edge |
| sda_pull | output | 1 | Pull SDA low when 1 |
| scl_pull | output | 1 | Pull SCL low when 1 |
| underrun | output | 1 | One-cycle pulse: no bit in no-stretch mode |

## Verification
The assertions assume that presc, hold_q, setup_q, filt_len and no_stretch change only while the sequencer is idle. They also assume that no further SCL falling edge is requested while a bit is still in progress. The bench meets both assumptions: it writes the settings only between bit sequences, and it raises SCL again only after the whole sequence has finished and the filter has had time to settle. bit_valid is dropped only after the edge at which the bit was taken.

// File: rtl/i2cbt_pkg.sv
// Shared types for the I2C bit timing sequencer.
package i2cbt_pkg;
    // Sequencer phases between one SCL fall and the SCL release
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_SETUP = 2'd3
    } seq_state_t;
endpackage

// File: rtl/i2cbt_line_filter.sv
// Synchronizes the raw SCL line and rejects pulses shorter than filt_len
// samples. Emits a one-cycle pulse when the accepted level falls.
// Assumes SYNC_STAGES >= 2. filt_len = 0 means accept after one sample.
module i2cbt_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic [FILT_W-1:0] filt_len,
    output logic              fall_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   samp;
    logic                   level_q;
    logic [FILT_W-1:0]      run_q;
    logic [FILT_W:0]        run_next;

    // Shift chain bringing the line into the clock domain (idle high)
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
    end

    assign samp     = sync_q[SYNC_STAGES-1];
    assign run_next = {1'b0, run_q} + {{FILT_W{1'b0}}, 1'b1};

    // Accepts a new level after enough differing samples in a row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q    <= 1'b1;
            run_q      <= '0;
            fall_pulse <= 1'b0;
        end else begin
            fall_pulse <= 1'b0;
            if (samp == level_q) begin
                run_q <= '0;
            end else if (filt_len == '0 || run_next >= {1'b0, filt_len}) begin
                level_q    <= samp;
                run_q      <= '0;
                fall_pulse <= level_q & ~samp;
            end else begin
                run_q <= run_next[FILT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/i2cbt_quanta_timer.sv
// Counts quanta * (presc + 1) clock edges after start. done is a one-cycle
// pulse right after the last counted edge. quanta = 0 gives done at once.
// Assumes no start while a count is running.
module i2cbt_quanta_timer #(
    parameter int PRESC_W = 4,
    parameter int Q_W     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [Q_W-1:0]     quanta,
    input  logic [PRESC_W-1:0] presc,
    output logic               done
);
    logic               busy_q;
    logic [Q_W-1:0]     quant_q;
    logic [PRESC_W-1:0] tick_q;

    // Prescaler plus quantum down-counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            quant_q <= '0;
            tick_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                if (quanta == '0) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    busy_q  <= 1'b1;
                    quant_q <= quanta;
                    tick_q  <= presc;
                end
            end else if (busy_q) begin
                if (tick_q == '0) begin
                    if (quant_q == {{(Q_W-1){1'b0}}, 1'b1}) begin
                        busy_q <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        quant_q <= quant_q - 1'b1;
                        tick_q  <= presc;
                    end
                end else begin
                    tick_q <= tick_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_bit_timer.sv
// Top of the I2C bit timing sequencer. On a filtered SCL fall it waits the
// hold delay, drives the next bit on SDA, then (stretching mode) keeps SCL
// low for the setup delay. Assumes settings are static while not idle.
module i2c_bit_timer
    import i2cbt_pkg::*;
#(
    parameter int PRESC_W     = 4,
    parameter int DLY_W       = 4,
    parameter int FILT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               bit_data,
    input  logic               bit_valid,
    input  logic [PRESC_W-1:0] presc,
    input  logic [DLY_W-1:0]   hold_q,
    input  logic [DLY_W-1:0]   setup_q,
    input  logic [FILT_W-1:0]  filt_len,
    input  logic               no_stretch,
    output logic               bit_taken,
    output logic               sda_pull,
    output logic               scl_pull,
    output logic               underrun
);
    localparam int Q_W = DLY_W + 1;

    seq_state_t     state_q;
    logic           scl_fall;
    logic           tmr_start;
    logic           tmr_done;
    logic [Q_W-1:0] tmr_quanta;
    logic [Q_W-1:0] setup_len;

    i2cbt_line_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_W     (FILT_W)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (scl_in),
        .filt_len  (filt_len),
        .fall_pulse(scl_fall)
    );

    i2cbt_quanta_timer #(
        .PRESC_W(PRESC_W),
        .Q_W    (Q_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .quanta(tmr_quanta),
        .presc (presc),
        .done  (tmr_done)
    );

    assign setup_len = {1'b0, setup_q} + {{DLY_W{1'b0}}, 1'b1};

    // Picks which delay to start and when the bit is consumed
    always_comb begin
        tmr_start  = 1'b0;
        tmr_quanta = {1'b0, hold_q};
        bit_taken  = 1'b0;
        case (state_q)
            ST_IDLE: tmr_start = scl_fall;
            ST_HOLD: begin
                if (tmr_done && bit_valid) begin
                    bit_taken  = 1'b1;
                    tmr_start  = !no_stretch;
                    tmr_quanta = setup_len;
                end
            end
            ST_WAIT: begin
                if (bit_valid) begin
                    bit_taken  = 1'b1;
                    tmr_start  = 1'b1;
                    tmr_quanta = setup_len;
                end
            end
            default: ;
        endcase
    end

    // Phase sequencing, SDA drive and underrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            sda_pull <= 1'b0;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            case (state_q)
                ST_IDLE: if (scl_fall) state_q <= ST_HOLD;
                ST_HOLD: begin
                    if (tmr_done) begin
                        if (bit_valid) begin
                            sda_pull <= ~bit_data;
                            state_q  <= no_stretch ? ST_IDLE : ST_SETUP;
                        end else if (no_stretch) begin
                            sda_pull <= 1'b0;
                            underrun <= 1'b1;
                            state_q  <= ST_IDLE;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (bit_valid) begin
                        sda_pull <= ~bit_data;
                        state_q  <= ST_SETUP;
                    end
                end
                ST_SETUP: if (tmr_done) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // SCL is held low from the fall until the setup delay has elapsed
    always_comb begin
        scl_pull = 1'b0;
        if (!no_stretch) begin
            scl_pull = (state_q == ST_HOLD) || (state_q == ST_WAIT) ||
                       (state_q == ST_SETUP && !tmr_done);
        end
    end
endmodule

// File: rtl/i2c_bit_timer_chk.sv
// Property checker for i2c_bit_timer, attached by bind below.
// Assumes settings change only while the sequencer is idle.
module i2c_bit_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic no_stretch,
    input logic bit_taken,
    input logic sda_pull,
    input logic scl_pull,
    input logic underrun
);
    // R5: in stretching mode SDA only moves while SCL is held low
    p_sda_moves_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!no_stretch && !$stable(sda_pull)) |-> scl_pull);

    // R5: SCL is still held in the cycle after the bit is taken
    p_held_after_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_taken && !no_stretch) |=> scl_pull);

    // R3: a bit is consumed for a single cycle only
    p_taken_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_taken |=> !bit_taken);

    // R7: no-stretch mode never pulls SCL
    p_no_pull_r7: assert property (@(posedge clk) disable iff (!rst_n)
        no_stretch |-> !scl_pull);

    // R8: underrun lasts one cycle
    p_underrun_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

    // R8: underrun only in no-stretch mode, with SDA released
    p_underrun_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (no_stretch && !sda_pull));
endmodule

bind i2c_bit_timer i2c_bit_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .no_stretch(no_stretch),
    .bit_taken (bit_taken),
    .sda_pull  (sda_pull),
    .scl_pull  (scl_pull),
    .underrun  (underrun)
);

// File: tb/i2c_bit_timer_bench.sv
`timescale 1ns/1ps
module i2c_bit_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       scl_line;
    logic       bit_data = 1'b1;
    logic       bit_valid = 1'b0;
    logic [3:0] presc = '0, hold_q = '0, setup_q = '0, filt_len = '0;
    logic       no_stretch = 1'b0;
    logic       bit_taken, sda_pull, scl_pull, underrun;
    int         cyc = 0;
    int         checks = 0;
    int         failures = 0;
    bit         done_flag = 1'b0;

    // Vector fields: presc, hold_q, setup_q, filt_len, no_stretch, bit
    localparam logic [17:0] VECS [6] = '{
        {4'd0,  4'd0, 4'd0, 4'd0, 1'b0, 1'b0},
        {4'd1,  4'd2, 4'd3, 4'd0, 1'b0, 1'b1},
        {4'd3,  4'd4, 4'd1, 4'd2, 1'b0, 1'b0},
        {4'd0,  4'd5, 4'd7, 4'd3, 1'b0, 1'b1},
        {4'd2,  4'd3, 4'd2, 4'd1, 1'b1, 1'b0},
        {4'd15, 4'd1, 4'd0, 4'd0, 1'b0, 1'b1}
    };

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign scl_line = scl_drv & ~scl_pull;

    i2c_bit_timer u_i2c_bit_timer (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line),
        .bit_data(bit_data), .bit_valid(bit_valid),
        .presc(presc), .hold_q(hold_q), .setup_q(setup_q),
        .filt_len(filt_len), .no_stretch(no_stretch),
        .bit_taken(bit_taken), .sda_pull(sda_pull),
        .scl_pull(scl_pull), .underrun(underrun)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int max1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    // Watchdog: an expired run counts as a failure
    always @(posedge clk) begin
        if (cyc > 150000 && !done_flag) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int k, sda_e, rise_e, fall_e, und_e, und_n, exp_sda;
        bit pulled, prev;
        repeat (4) @(negedge clk);
        // R1: state under reset
        check(sda_pull == 1'b0 && scl_pull == 1'b0, "R1 reset lines", {sda_pull, scl_pull}, 0);
        check(underrun == 1'b0 && bit_taken == 1'b0, "R1 reset flags", {underrun, bit_taken}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Table walk: R2 R3 R4 R5 R7 across settings
        for (int v = 0; v < 6; v++) begin
            int p, hd, su, fl, n, m, hq;
            bit ns, b;
            {presc, hold_q, setup_q, filt_len, no_stretch, bit_data} = VECS[v];
            p = presc; hd = hold_q; su = setup_q; fl = filt_len;
            ns = no_stretch; b = bit_data;
            bit_valid = 1'b1;
            prev = sda_pull;
            @(negedge clk);
            scl_drv = 1'b0;
            k = cyc + 1;
            sda_e = -1; rise_e = -1; fall_e = -1; pulled = 1'b0;
            for (int i = 0; i < 700; i++) begin
                @(negedge clk);
                if (sda_e < 0 && sda_pull != prev) sda_e = cyc;
                if (sda_e >= 0) bit_valid = 1'b0;
                if (scl_pull) pulled = 1'b1;
                if (rise_e < 0 && scl_pull) rise_e = cyc;
                if (rise_e >= 0 && fall_e < 0 && !scl_pull) fall_e = cyc;
            end
            hq = max1(fl);
            n = hd * (p + 1);
            m = (su + 1) * (p + 1);
            exp_sda = k + 3 + hq + n;
            check(sda_e == exp_sda, "R3 sda edge (R2 filter latency)", sda_e - k, exp_sda - k);
            check(sda_pull == !b, "R3 sda value", sda_pull, !b);
            if (!ns) begin
                check(rise_e == k + 2 + hq, "R4 scl hold start", rise_e - k, 2 + hq);
                check(fall_e == exp_sda + m, "R5 scl release", fall_e - exp_sda, m);
            end else begin
                check(pulled == 1'b0, "R7 no scl pull", pulled, 0);
            end
            scl_drv = 1'b1;
            repeat (12) @(negedge clk);
        end

        // R6: late bit in stretching mode
        presc = 4'd1; hold_q = 4'd1; setup_q = 4'd2; filt_len = 4'd0; no_stretch = 1'b0;
        bit_valid = 1'b0; bit_data = 1'b0;
        @(negedge clk);
        scl_drv = 1'b0;
        repeat (60) @(negedge clk);
        check(scl_pull == 1'b1, "R6 stretched while waiting", scl_pull, 1);
        check(sda_pull == 1'b0, "R6 sda unchanged while waiting", sda_pull, 0);
        bit_valid = 1'b1;
        #1;
        check(bit_taken == 1'b1, "R6 bit taken on arrival", bit_taken, 1);
        k = cyc + 1;
        sda_e = -1; fall_e = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sda_e < 0 && sda_pull) sda_e = cyc;
            if (sda_e >= 0) bit_valid = 1'b0;
            if (fall_e < 0 && !scl_pull) fall_e = cyc;
        end
        check(sda_e == k, "R6 sda at arrival edge", sda_e - k, 0);
        check(fall_e == k + 6, "R6 full setup after arrival", fall_e - k, 6);
        scl_drv = 1'b1;
        repeat (12) @(negedge clk);

        // R8: underrun in no-stretch mode (sda currently pulled)
        presc = 4'd0; hold_q = 4'd2; setup_q = 4'd0; no_stretch = 1'b1;
        bit_valid = 1'b0;
        @(negedge clk);
        scl_drv = 1'b0;
        k = cyc + 1;
        und_e = -1; und_n = 0; pulled = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (underrun) begin
                und_n++;
                if (und_e < 0) und_e = cyc;
            end
            if (scl_pull) pulled = 1'b1;
        end
        check(und_e == k + 6, "R8 underrun edge", und_e - k, 6);
        check(und_n == 1, "R8 underrun width", und_n, 1);
        check(sda_pull == 1'b0, "R8 sda released", sda_pull, 0);
        check(pulled == 1'b0, "R7 no pull on underrun", pulled, 0);
        scl_drv = 1'b1;
        repeat (12) @(negedge clk);

        // R2: short glitch is rejected
        no_stretch = 1'b0; filt_len = 4'd3; bit_valid = 1'b1; bit_data = 1'b0;
        @(negedge clk);
        scl_drv = 1'b0;
        repeat (2) @(negedge clk);
        scl_drv = 1'b1;
        pulled = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (scl_pull) pulled = 1'b1;
        end
        check(pulled == 1'b0, "R2 glitch scl", pulled, 0);
        check(sda_pull == 1'b0, "R2 glitch sda", sda_pull, 0);
        bit_valid = 1'b0;
        filt_len = 4'd0;

        // R1: reset in the middle of a stretched bit
        @(negedge clk);
        scl_drv = 1'b0;
        repeat (20) @(negedge clk);
        check(scl_pull == 1'b1, "R1 held before reset", scl_pull, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(scl_pull == 1'b0 && sda_pull == 1'b0, "R1 mid-bit reset", {scl_pull, sda_pull}, 0);
        scl_drv = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(scl_pull == 1'b0 && underrun == 1'b0, "R1 idle after reset", {scl_pull, underrun}, 0);

        done_flag = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule